// File: doc/BRIEF.md
# Shared Data-Ready Serial Output Port

This block drives one output pin that does two jobs in turn. Each conversion frame of 384 system clocks opens with a 36-clock ready window. In that window the pin follows a fixed HIGH/LOW/HIGH pattern, and a host watching the pin uses the LOW pulse to learn that a new result is waiting. The other 348 clocks form the data window. In the data window the pin presents a 24-bit result one bit at a time, most significant bit first. The host advances the pin by one bit with each falling edge of its own serial clock and samples the pin on the rising edges.

A filter upstream hands over each new result with a one-cycle valid strobe. The port keeps the most recent word and moves it into its output register during the low part of the ready window. The serial clock has no fixed relation to the system clock. It is brought in through a two-flop synchronizer, and only its falling edges are used. Reads that stop early, reads that run past the last bit, and frames with no read at all each leave the pin in a defined state. Every frame's read starts again from the most significant bit.

Top module: `rdy_shift_port`

## Requirements
- R1: Counting from the first clock after reset, a frame is 384 clocks long. While reset is held the pin is HIGH.
- R2: Within each frame, the pin is HIGH in cycles 0 to 23, LOW in cycles 24 to 29 and HIGH in cycles 30 to 35. Cycles 36 to 383 are the data window.
- R3: A strobe on `loadValid` stores `loadData`. The stored word enters the output register at the clock edge of frame cycle 24. In the data window the register is read MSB first (bit 23 first), and each detected falling edge of `sclkIn` moves the pin to the next lower bit.
- R4: If the data window sees no falling edge, the pin shows bit 23 of the current word until cycle 383.
- R5: After k falling edges, with 1 <= k <= 23, the pin holds bit 23-k until the data window ends.
- R6: After 24 or more falling edges, the pin is LOW for the rest of the data window.
- R7: The bit position is cleared at frame cycles 0 and 24. The first data-window bit of every frame is therefore bit 23 of the newly transferred word, however many edges the previous frame received.
- R8: Falling edges of `sclkIn` detected while the frame is in cycles 0 to 35 have no effect on the data-window output.
- R9: A strobe in the same cycle as the transfer is stored, but it reaches the pin only in the following frame. If no strobe arrives, the stored word is sent again.
- R10: The pin changes because of a falling edge of `sclkIn` at the third rising clock edge after `sclkIn` is first sampled LOW, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadValid | input | 1 | One-cycle strobe from the filter |
| loadData | input | 24 | Result word from the filter, two's complement |
| sclkIn | input | 1 | Host serial clock, asynchronous, idle LOW |
| pinOut | output | 1 | Shared ready-pulse and serial data output |

## Verification
The assertions assume that the serial clock stays at each level for at least three system clocks, so that the synchronizer sees every edge. They also assume that the host counts frames from reset in the same way the port does. The stimulus keeps `sclkIn` HIGH and LOW for four clocks each. It starts reads only after frame cycle 36, finishes them before the window closes, and gives all ready-window toggles time to settle before cycle 36. Strobes arrive one cycle at a time, including one placed exactly on the transfer cycle.

// File: rtl/rdy_shift_pkg.sv
package rdy_shift_pkg;
  typedef enum logic [1:0] {
    PIN_HIGH = 2'd0,
    PIN_LOW  = 2'd1,
    PIN_DATA = 2'd2
  } pinMode_e;

  typedef struct packed {
    logic     clrPtr;
    logic     xfer;
    logic     shift;
    pinMode_e mode;
  } portCtl_t;
endpackage

// File: rtl/rdy_shift_ctrl.sv
module rdy_shift_ctrl
  import rdy_shift_pkg::*;
#(
  parameter int FRAME_LEN   = 384,
  parameter int PRE_HI      = 24,
  parameter int WR_LEN      = 6,
  parameter int POST_HI     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclkIn,
  input  logic     ptrFull,
  output portCtl_t ctl
);
  localparam int CNT_W   = $clog2(FRAME_LEN);
  localparam int WR_END  = PRE_HI + WR_LEN;
  localparam int RDY_LEN = WR_END + POST_HI;

  logic [CNT_W-1:0]     frameCnt;
  logic [SYNC_STAGES:0] sclkPipe;
  logic                 sclkFall;
  logic                 inData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameCnt <= '0;
    else if (frameCnt == CNT_W'(FRAME_LEN - 1)) frameCnt <= '0;
    else frameCnt <= frameCnt + 1'b1;
  end

  // pipe[0..SYNC_STAGES-1] synchronize, pipe[SYNC_STAGES] keeps the previous level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPipe <= '0;
    else       sclkPipe <= {sclkPipe[SYNC_STAGES-1:0], sclkIn};
  end

  assign sclkFall = sclkPipe[SYNC_STAGES] & ~sclkPipe[SYNC_STAGES-1];
  assign inData   = (frameCnt >= CNT_W'(RDY_LEN));

  always_comb begin
    ctl.clrPtr = (frameCnt == '0) || (frameCnt == CNT_W'(PRE_HI));
    ctl.xfer   = (frameCnt == CNT_W'(PRE_HI));
    ctl.shift  = sclkFall && inData && !ptrFull;
    if (inData)                                                   ctl.mode = PIN_DATA;
    else if (frameCnt >= CNT_W'(PRE_HI) && frameCnt < CNT_W'(WR_END)) ctl.mode = PIN_LOW;
    else                                                          ctl.mode = PIN_HIGH;
  end
endmodule

// File: rtl/rdy_shift_dp.sv
module rdy_shift_dp
  import rdy_shift_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  portCtl_t                    ctl,
  input  logic                        loadValid,
  input  logic [DATA_W-1:0]           loadData,
  output logic [$clog2(DATA_W+1)-1:0] bitPtr,
  output logic                        ptrFull,
  output logic                        pinOut
);
  localparam int PTR_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] heldWord;
  logic [DATA_W-1:0] outReg;
  logic [PTR_W-1:0]  bitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldWord <= '0;
      outReg   <= '0;
    end else begin
      if (loadValid) heldWord <= loadData;
      if (ctl.xfer)  outReg   <= heldWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           bitPtr <= '0;
    else if (ctl.clrPtr) bitPtr <= '0;
    else if (ctl.shift)  bitPtr <= bitPtr + 1'b1;
  end

  assign ptrFull = (bitPtr == PTR_W'(DATA_W));
  assign bitIdx  = PTR_W'(DATA_W - 1) - bitPtr;

  always_comb begin
    unique case (ctl.mode)
      PIN_LOW:  pinOut = 1'b0;
      PIN_DATA: pinOut = ptrFull ? 1'b0 : outReg[bitIdx];
      default:  pinOut = 1'b1;
    endcase
  end
endmodule

// File: rtl/rdy_shift_port.sv
module rdy_shift_port
  import rdy_shift_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int FRAME_LEN   = 384,
  parameter int PRE_HI      = 24,
  parameter int WR_LEN      = 6,
  parameter int POST_HI     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadValid,
  input  logic [DATA_W-1:0] loadData,
  input  logic              sclkIn,
  output logic              pinOut
);
  localparam int PTR_W = $clog2(DATA_W + 1);

  portCtl_t         ctl;
  logic [PTR_W-1:0] bitPtr;
  logic             ptrFull;

  rdy_shift_ctrl #(
    .FRAME_LEN(FRAME_LEN), .PRE_HI(PRE_HI), .WR_LEN(WR_LEN),
    .POST_HI(POST_HI), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .ptrFull(ptrFull), .ctl(ctl)
  );

  rdy_shift_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .loadValid(loadValid),
    .loadData(loadData), .bitPtr(bitPtr), .ptrFull(ptrFull), .pinOut(pinOut)
  );
endmodule

// File: rtl/rdy_shift_chk.sv
module rdy_shift_chk
  import rdy_shift_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int FRAME_LEN = 384,
  parameter int PRE_HI    = 24,
  parameter int WR_LEN    = 6,
  parameter int POST_HI   = 6
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        pinOut,
  input portCtl_t                    ctl,
  input logic [$clog2(DATA_W+1)-1:0] bitPtr
);
  localparam int CNT_W   = $clog2(FRAME_LEN);
  localparam int PTR_W   = $clog2(DATA_W + 1);
  localparam int WR_END  = PRE_HI + WR_LEN;
  localparam int RDY_LEN = WR_END + POST_HI;

  // independent frame position, counted from reset
  logic [CNT_W-1:0] chkCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chkCnt <= '0;
    else if (chkCnt == CNT_W'(FRAME_LEN - 1)) chkCnt <= '0;
    else chkCnt <= chkCnt + 1'b1;
  end

  logic inLow, inData, lastCyc;
  assign inLow   = chkCnt >= CNT_W'(PRE_HI) && chkCnt < CNT_W'(WR_END);
  assign inData  = chkCnt >= CNT_W'(RDY_LEN);
  assign lastCyc = chkCnt == CNT_W'(FRAME_LEN - 1);

  p_ready_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!inData && !inLow) |-> pinOut);
  p_ready_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    inLow |-> !pinOut);
  p_ptr_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrPtr |=> (bitPtr == '0));
  p_ptr_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    bitPtr <= PTR_W'(DATA_W));
  p_over_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inData && bitPtr == PTR_W'(DATA_W)) |-> !pinOut);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inData && !lastCyc && !ctl.shift) |=> $stable(pinOut));
  p_ready_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    !inData |-> !ctl.shift);
endmodule

bind rdy_shift_port rdy_shift_chk #(
  .DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .PRE_HI(PRE_HI),
  .WR_LEN(WR_LEN), .POST_HI(POST_HI)
) u_chk (
  .clk(clk), .rstN(rstN), .pinOut(pinOut), .ctl(ctl), .bitPtr(bitPtr)
);

// File: tb/tb_rdy_shift_port.sv
`timescale 1ns/1ps
module tb_rdy_shift_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadValid = 1'b0;
  logic [23:0] loadData = '0;
  logic        sclkIn = 1'b0;
  logic        pinOut;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  rdy_shift_port dut (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadData(loadData),
    .sclkIn(sclkIn), .pinOut(pinOut)
  );

  always #5 clk = ~clk;

  // behavioural reference
  int          mCnt = 0;
  int          mPtr = 0;
  logic [23:0] mHeld = '0;
  logic [23:0] mOut = '0;
  bit          sHist[$] = '{0, 0, 0};  // [0] newest sample

  function automatic bit expPin();
    if (!rstN)     return 1'b1;
    if (mCnt < 24) return 1'b1;
    if (mCnt < 30) return 1'b0;
    if (mCnt < 36) return 1'b1;
    if (mPtr >= 24) return 1'b0;
    return mOut[23 - mPtr];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mPtr = 0; mHeld = '0; mOut = '0; sHist = '{0, 0, 0};
    end else begin
      bit fall, clr, xfer;
      fall = sHist[2] && !sHist[1];
      clr  = (mCnt == 0) || (mCnt == 24);
      xfer = (mCnt == 24);
      if (xfer) mOut = mHeld;
      if (loadValid) mHeld = loadData;
      if (clr) mPtr = 0;
      else if (fall && mCnt >= 36 && mPtr < 24) mPtr++;
      mCnt = (mCnt + 1) % 384;
      sHist.push_front(sclkIn);
      void'(sHist.pop_back());
    end
  end

  task automatic check(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pin=%0b expected=%0b at frame cycle %0d", req, act, exp, mCnt);
    end
  endtask

  task automatic checkWord(string req, logic [23:0] act, logic [23:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: word=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    string lbl;
    cycles++;
    if (!rstN || mCnt < 24)   lbl = "R1";
    else if (mCnt < 36)       lbl = "R2";
    else if (mPtr == 0)       lbl = "R4";
    else if (mPtr < 24)       lbl = "R5";
    else                      lbl = "R6";
    check(lbl, pinOut, expPin());
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: pin=%0b expected=finish", pinOut);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic waitCnt(int n);
    @(negedge clk);
    while (mCnt != n) @(negedge clk);
  endtask

  task automatic strobe(logic [23:0] w);
    loadData = w; loadValid = 1'b1;
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  task automatic readBits(int n, output logic [23:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      got = {got[22:0], pinOut};
      sclkIn = 1'b1; repeat (4) @(negedge clk);
      sclkIn = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  logic [23:0] got;
  localparam logic [23:0] WA = 24'h5A3C96;
  localparam logic [23:0] WB = 24'hC01234;
  localparam logic [23:0] WC = 24'h2D71E8;
  localparam logic [23:0] WD = 24'hFFFF0F;
  localparam logic [23:0] WE = 24'h9B4C21;
  localparam logic [23:0] WF = 24'h13579B;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", pinOut, 1'b1);
    rstN = 1'b1;

    // frame 0: full read
    waitCnt(5); strobe(WA);
    waitCnt(40);
    check("R3 first bit", pinOut, WA[23]);
    readBits(24, got);
    checkWord("R3 full read", got, WA);
    waitCnt(300);
    check("R6 after 24 edges", pinOut, 1'b0);

    // frame 1: no read
    waitCnt(5); strobe(WB);
    waitCnt(200);
    check("R4 idle holds msb", pinOut, WB[23]);
    waitCnt(383);
    check("R4 idle at window end", pinOut, WB[23]);

    // frame 2: latency, then partial read of 10 bits
    waitCnt(5); strobe(WC);
    waitCnt(40);
    sclkIn = 1'b1; repeat (4) @(negedge clk);
    sclkIn = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 not yet", pinOut, WC[23]);
    @(negedge clk);
    check("R10 third edge", pinOut, WC[22]);
    @(negedge clk);
    readBits(9, got);
    checkWord("R5 partial bits", got, {15'd0, WC[22:14]});
    waitCnt(380);
    check("R5 holds last shifted", pinOut, WC[13]);

    // frame 3: over-read of 30 pulses
    waitCnt(5); strobe(WD);
    waitCnt(40);
    readBits(30, got);
    check("R6 over-read low", pinOut, 1'b0);

    // frame 4: toggles during ready window, then fresh read
    waitCnt(3); strobe(WE);
    for (int k = 0; k < 3; k++) begin
      sclkIn = 1'b1; repeat (4) @(negedge clk);
      sclkIn = 1'b0; repeat (4) @(negedge clk);
    end
    waitCnt(40);
    check("R7 fresh msb after over-read", pinOut, WE[23]);
    readBits(24, got);
    checkWord("R8 ready-window edges ignored", got, WE);

    // frame 5: strobe on the transfer cycle
    waitCnt(24); strobe(WF);
    waitCnt(40);
    readBits(24, got);
    checkWord("R9 same-cycle strobe deferred", got, WE);

    // frame 6: deferred word appears
    waitCnt(40);
    check("R7 msb of new word", pinOut, WF[23]);
    readBits(24, got);
    checkWord("R9 deferred word sent", got, WF);

    waitCnt(10);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule